// File: doc/BRIEF.md
# Package Idle-State Coordinator

This block merges the idle-state requests of several processor cores into a single package-level idle state. Each core presents a requested state code and an active flag. The block takes the shallowest request among the active cores. It then applies two platform limits: a permission ceiling on depth and a hold that keeps the package shallow. When enhanced C1 is enabled, a resolved C1 is reported as C1E. While the package sits in C3 or C6, the block asks for DRAM self-refresh.

Break events wake the package. A core break event wakes its target core. If the event is unmasked, the package is pinned at C0 until that core has woken. If it is masked, the package goes back to the state it left. A memory or snoop break event raises a service strobe. Afterwards the package returns to its earlier state, unless the platform hold asks it to stay shallow. All outputs are registered, so each one follows its inputs by one clock.

Top module: `pkg_idle_coord`

## Requirements
- R1: After reset the package state is C0, self-refresh is low, no wake bit is set and the service strobe is low.
- R2: State codes are C0=0, C1=1, C1E=2, C3=3, C6=6. A core code is first mapped to the deepest legal core state that is no deeper than the code: 2 becomes C1, 4 and 5 become C3, 7 becomes C6. In normal operation the package state one clock later is the shallowest mapped request among the active cores (C3 and C6 give C3, and any C0 gives C0).
- R3: Cores whose active flag is low do not take part in the minimum. With no active core, the request is C6 before the limits are applied.
- R4: The platform ceiling is mapped the same way and caps the package depth. The cores themselves may request deeper states than the package takes.
- R5: While the platform hold is high, the package is capped at C1.
- R6: With enhanced C1 enabled, a resolved C1 is reported as C1E (code 2). Disabled, it stays C1.
- R7: The self-refresh request is high exactly while the package state is C3 or C6.
- R8: The package moves directly between idle states as requests change, without passing through C0.
- R9: An unmasked core break sets the package to C0 and pulses that core's wake bit for one cycle. The package then holds C0 until that core requests C0 or goes inactive. On the clock after that, normal resolution resumes.
- R10: A masked core break pulses the wake bit and sets C0 for one cycle. On the next cycle the saved previous state is restored, but never deeper than the current resolution. Normal resolution follows after that.
- R11: A memory/snoop break with the hold low pulses the service strobe for one cycle with the package in C0. The package then restores its previous state as in R10.
- R12: A memory/snoop break with the hold high pulses the strobe and sets C0. The next cycle uses normal (held) resolution, with no restore.
- R13: Only one break is accepted per cycle. Among core breaks, the lowest-numbered core wins. A memory/snoop break that arrives together with any core break is dropped and produces no strobe.
- R14: The previous state is saved only when a break arrives in normal operation. A break that arrives during a restore or wake-hold cycle keeps the earlier saved state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | NUM_CORES*3 | Per-core requested state code, core i in bits [3i+2:3i] |
| core_active | input | NUM_CORES | Per-core active flag |
| plat_limit | input | 3 | Deepest state the platform permits |
| plat_hold | input | 1 | Platform asks the package to stay shallow |
| c1e_en | input | 1 | Enhanced C1 enable |
| core_brk | input | NUM_CORES | Per-core break event pulse |
| core_brk_mask | input | NUM_CORES | Per-core mask flag for the break event |
| mem_brk | input | 1 | Memory access or snoop break pulse |
| pkg_state | output | 3 | Resolved package idle state |
| dram_sr | output | 1 | DRAM self-refresh request |
| core_wake | output | NUM_CORES | One-cycle wake pulse to the target core |
| svc_strobe | output | 1 | One-cycle memory/snoop service strobe |

## Verification
The bench drives a masked break into a package whose cores have since asked for a deeper state. A design that skips the restore cycle shows C6 where C3 is expected. A break that lands during a restore cycle must not overwrite the saved state; if it does, the later restore comes back as C0. Simultaneous core and memory breaks check that the lowest core wins and that no stray strobe appears. Releasing a wake hold through an inactive target checks that the hold tracks the right core. Illegal request and ceiling codes check the mapping, since a design without it produces unlisted state codes or the wrong depth.

// File: rtl/pkg_idle_pkg.sv
package pkg_idle_pkg;

    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        PS_C0  = 3'd0,
        PS_C1  = 3'd1,
        PS_C1E = 3'd2,
        PS_C3  = 3'd3,
        PS_C6  = 3'd6
    } pstate_e;

    typedef enum logic [1:0] {
        MD_RUN     = 2'd0,
        MD_RESTORE = 2'd1,
        MD_WAKE    = 2'd2
    } mode_e;

    // Map any 3-bit code to the deepest legal core state not deeper than it.
    function automatic pstate_e legalize(input logic [ST_W-1:0] code);
        pstate_e r;
        case (code)
            3'd0:           r = PS_C0;
            3'd1, 3'd2:     r = PS_C1;
            3'd3, 3'd4,
            3'd5:           r = PS_C3;
            default:        r = PS_C6;
        endcase
        return r;
    endfunction

    function automatic pstate_e shallower(input pstate_e a, input pstate_e b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/idle_req_resolve.sv
module idle_req_resolve
    import pkg_idle_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES*ST_W-1:0] core_req,
    input  logic [NUM_CORES-1:0]      core_active,
    input  logic [ST_W-1:0]           plat_limit,
    input  logic                      plat_hold,
    input  logic                      c1e_en,
    output pstate_e                   resolved
);

    pstate_e eff   [NUM_CORES];
    pstate_e chain [NUM_CORES+1];
    pstate_e capped;

    assign chain[0] = PS_C6;

    // Minimum-reduction chain across active cores.
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        assign eff[g]     = core_active[g] ? legalize(core_req[g*ST_W +: ST_W]) : PS_C6;
        assign chain[g+1] = shallower(chain[g], eff[g]);
    end

    always_comb begin
        capped = shallower(chain[NUM_CORES], legalize(plat_limit));
        if (plat_hold) begin
            capped = shallower(capped, PS_C1);
        end
        resolved = capped;
        if (capped == PS_C1 && c1e_en) begin
            resolved = PS_C1E;
        end
    end

endmodule

// File: rtl/brk_arbiter.sv
module brk_arbiter #(
    parameter int NUM_CORES = 4,
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic [NUM_CORES-1:0] core_brk,
    input  logic [NUM_CORES-1:0] core_brk_mask,
    input  logic                 mem_brk,
    output logic                 core_hit,
    output logic [IDX_W-1:0]     core_idx,
    output logic                 core_masked,
    output logic                 mem_hit
);

    always_comb begin
        core_hit = 1'b0;
        core_idx = '0;
        // Descending scan so the lowest-numbered core wins.
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (core_brk[i]) begin
                core_hit = 1'b1;
                core_idx = IDX_W'(i);
            end
        end
        core_masked = core_brk_mask[core_idx];
        mem_hit     = mem_brk & ~core_hit;
    end

endmodule

// File: rtl/pkg_idle_coord.sv
module pkg_idle_coord
    import pkg_idle_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CORES*3-1:0]    core_req,
    input  logic [NUM_CORES-1:0]      core_active,
    input  logic [2:0]                plat_limit,
    input  logic                      plat_hold,
    input  logic                      c1e_en,
    input  logic [NUM_CORES-1:0]      core_brk,
    input  logic [NUM_CORES-1:0]      core_brk_mask,
    input  logic                      mem_brk,
    output logic [2:0]                pkg_state,
    output logic                      dram_sr,
    output logic [NUM_CORES-1:0]      core_wake,
    output logic                      svc_strobe
);

    typedef struct packed {
        pstate_e              pkg;
        pstate_e              prev;
        mode_e                mode;
        logic [IDX_W-1:0]     tgt;
        logic [NUM_CORES-1:0] wake;
        logic                 svc;
        logic                 sr;
    } coord_t;

    coord_t st_d, st_q;

    pstate_e          resolved;
    logic             core_hit, core_masked, mem_hit;
    logic [IDX_W-1:0] core_idx;
    logic [ST_W-1:0]  tgt_code;
    logic             tgt_active;
    logic             tgt_released;

    idle_req_resolve #(.NUM_CORES(NUM_CORES)) u_resolve (
        .core_req    (core_req),
        .core_active (core_active),
        .plat_limit  (plat_limit),
        .plat_hold   (plat_hold),
        .c1e_en      (c1e_en),
        .resolved    (resolved)
    );

    brk_arbiter #(.NUM_CORES(NUM_CORES)) u_arb (
        .core_brk      (core_brk),
        .core_brk_mask (core_brk_mask),
        .mem_brk       (mem_brk),
        .core_hit      (core_hit),
        .core_idx      (core_idx),
        .core_masked   (core_masked),
        .mem_hit       (mem_hit)
    );

    // Select the request and activity of the core being woken.
    always_comb begin
        tgt_code   = '0;
        tgt_active = 1'b0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (IDX_W'(i) == st_q.tgt) begin
                tgt_code   = core_req[i*ST_W +: ST_W];
                tgt_active = core_active[i];
            end
        end
        tgt_released = !tgt_active || (legalize(tgt_code) == PS_C0);
    end

    always_comb begin
        st_d      = st_q;
        st_d.wake = '0;
        st_d.svc  = 1'b0;
        if (core_hit) begin
            if (st_q.mode == MD_RUN) begin
                st_d.prev = st_q.pkg;
            end
            st_d.pkg  = PS_C0;
            st_d.wake = NUM_CORES'(1) << core_idx;
            st_d.tgt  = core_idx;
            st_d.mode = core_masked ? MD_RESTORE : MD_WAKE;
        end else if (mem_hit) begin
            if (st_q.mode == MD_RUN) begin
                st_d.prev = st_q.pkg;
            end
            st_d.pkg  = PS_C0;
            st_d.svc  = 1'b1;
            st_d.mode = plat_hold ? MD_RUN : MD_RESTORE;
        end else begin
            case (st_q.mode)
                MD_RESTORE: begin
                    st_d.pkg  = shallower(st_q.prev, resolved);
                    st_d.mode = MD_RUN;
                end
                MD_WAKE: begin
                    if (tgt_released) begin
                        st_d.pkg  = resolved;
                        st_d.mode = MD_RUN;
                    end else begin
                        st_d.pkg  = PS_C0;
                    end
                end
                default: begin
                    st_d.pkg = resolved;
                end
            endcase
        end
        st_d.sr = (st_d.pkg == PS_C3) || (st_d.pkg == PS_C6);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pkg  <= PS_C0;
            st_q.prev <= PS_C0;
            st_q.mode <= MD_RUN;
            st_q.tgt  <= '0;
            st_q.wake <= '0;
            st_q.svc  <= 1'b0;
            st_q.sr   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pkg_state  = st_q.pkg;
    assign dram_sr    = st_q.sr;
    assign core_wake  = st_q.wake;
    assign svc_strobe = st_q.svc;

endmodule

// File: rtl/pkg_idle_coord_chk.sv
module pkg_idle_coord_chk #(
    parameter int NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           pkg_state,
    input logic                 dram_sr,
    input logic [NUM_CORES-1:0] core_wake,
    input logic                 svc_strobe,
    input logic [NUM_CORES-1:0] core_brk,
    input logic                 mem_brk
);

    a_r7_sr_tracks_depth: assert property (@(posedge clk) disable iff (!rst_n)
        dram_sr == (pkg_state == 3'd3 || pkg_state == 3'd6));

    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_state inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6});

    a_r9_wake_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_wake));

    a_r9_break_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_brk) |=> ($countones(core_wake) == 1 && pkg_state == 3'd0));

    a_r13_lowest_core: assert property (@(posedge clk) disable iff (!rst_n)
        core_brk[0] |=> core_wake[0]);

    a_r13_core_over_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_brk) |=> !svc_strobe);

    a_r11_mem_serviced: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_brk && !(|core_brk)) |=> (svc_strobe && pkg_state == 3'd0 && !dram_sr));

endmodule

bind pkg_idle_coord pkg_idle_coord_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkg_state  (pkg_state),
    .dram_sr    (dram_sr),
    .core_wake  (core_wake),
    .svc_strobe (svc_strobe),
    .core_brk   (core_brk),
    .mem_brk    (mem_brk)
);

// File: tb/tb_pkg_idle_coord.sv
module tb_pkg_idle_coord;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N*3-1:0] core_req;
    logic [N-1:0]   core_active;
    logic [2:0]     plat_limit;
    logic           plat_hold;
    logic           c1e_en;
    logic [N-1:0]   core_brk;
    logic [N-1:0]   core_brk_mask;
    logic           mem_brk;
    logic [2:0]     pkg_state;
    logic           dram_sr;
    logic [N-1:0]   core_wake;
    logic           svc_strobe;

    always #4 clk = ~clk;

    pkg_idle_coord #(.NUM_CORES(N)) dut (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_active(core_active),
        .plat_limit(plat_limit), .plat_hold(plat_hold), .c1e_en(c1e_en),
        .core_brk(core_brk), .core_brk_mask(core_brk_mask), .mem_brk(mem_brk),
        .pkg_state(pkg_state), .dram_sr(dram_sr), .core_wake(core_wake),
        .svc_strobe(svc_strobe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state (mode: 0 run, 1 restore, 2 wake-hold)
    logic [2:0]   m_pkg, m_prev;
    int           m_mode, m_tgt;
    logic [N-1:0] m_wake;
    logic         m_svc, m_sr;

    function automatic logic [2:0] legal(input logic [2:0] c);
        if (c == 3'd0) return 3'd0;
        if (c <= 3'd2) return 3'd1;
        if (c <= 3'd5) return 3'd3;
        return 3'd6;
    endfunction

    function automatic logic [2:0] mn(input logic [2:0] a, input logic [2:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [2:0] resolve_ref();
        logic [2:0] r = 3'd6;
        for (int i = 0; i < N; i++)
            if (core_active[i]) r = mn(r, legal(core_req[i*3 +: 3]));
        r = mn(r, legal(plat_limit));
        if (plat_hold) r = mn(r, 3'd1);
        if (r == 3'd1 && c1e_en) r = 3'd2;
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic [2:0]   n_pkg  = m_pkg;
        logic [2:0]   n_prev = m_prev;
        int           n_mode = m_mode;
        int           n_tgt  = m_tgt;
        logic [N-1:0] n_wake = '0;
        logic         n_svc  = 1'b0;
        int           ci     = -1;
        logic [2:0]   res    = resolve_ref();
        for (int i = 0; i < N; i++)
            if (core_brk[i] && ci < 0) ci = i;
        if (ci >= 0) begin
            if (m_mode == 0) n_prev = m_pkg;
            n_pkg  = 3'd0;
            n_wake = N'(1) << ci;
            n_tgt  = ci;
            n_mode = core_brk_mask[ci] ? 1 : 2;
        end else if (mem_brk) begin
            if (m_mode == 0) n_prev = m_pkg;
            n_pkg  = 3'd0;
            n_svc  = 1'b1;
            n_mode = plat_hold ? 0 : 1;
        end else if (m_mode == 1) begin
            n_pkg  = mn(m_prev, res);
            n_mode = 0;
        end else if (m_mode == 2) begin
            if (!core_active[m_tgt] || legal(core_req[m_tgt*3 +: 3]) == 3'd0) begin
                n_pkg  = res;
                n_mode = 0;
            end else begin
                n_pkg = 3'd0;
            end
        end else begin
            n_pkg = res;
        end
        @(posedge clk);
        #2;
        m_pkg = n_pkg; m_prev = n_prev; m_mode = n_mode; m_tgt = n_tgt;
        m_wake = n_wake; m_svc = n_svc;
        m_sr = (n_pkg == 3'd3) || (n_pkg == 3'd6);
        chk("R2 model pkg_state", int'(pkg_state), int'(m_pkg));
        chk("R7 model dram_sr", int'(dram_sr), int'(m_sr));
        chk("R9 model core_wake", int'(core_wake), int'(m_wake));
        chk("R11 model svc_strobe", int'(svc_strobe), int'(m_svc));
    endtask

    task automatic set_all(input logic [2:0] v);
        for (int i = 0; i < N; i++) core_req[i*3 +: 3] = v;
    endtask

    task automatic clr_brk();
        core_brk = '0; core_brk_mask = '0; mem_brk = 1'b0;
    endtask

    function automatic logic [2:0] rnd_code();
        int p = int'($urandom % 10);
        if (p < 2) return 3'd0;
        if (p < 4) return 3'd1;
        if (p < 6) return 3'd3;
        if (p < 8) return 3'd6;
        return 3'($urandom % 8);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1d1e));
        rst_n = 1'b0; core_req = '0; core_active = '1; plat_limit = 3'd6;
        plat_hold = 1'b0; c1e_en = 1'b0; clr_brk();
        m_pkg = 3'd0; m_prev = 3'd0; m_mode = 0; m_tgt = 0;
        m_wake = '0; m_svc = 1'b0; m_sr = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        chk("R1 pkg_state", int'(pkg_state), 0);
        chk("R1 dram_sr", int'(dram_sr), 0);
        chk("R1 core_wake", int'(core_wake), 0);
        chk("R1 svc_strobe", int'(svc_strobe), 0);

        // R2 shallowest request wins
        set_all(3'd6); core_req[2:0] = 3'd3; tick();
        chk("R2 C3+C6 gives C3", int'(pkg_state), 3);
        chk("R7 sr in C3", int'(dram_sr), 1);
        core_req[5:3] = 3'd0; tick();
        chk("R2 any C0 gives C0", int'(pkg_state), 0);
        set_all(3'd5); tick();
        chk("R2 code 5 maps to C3", int'(pkg_state), 3);
        set_all(3'd7); tick();
        chk("R2 code 7 maps to C6", int'(pkg_state), 6);
        set_all(3'd2); tick();
        chk("R2 code 2 maps to C1", int'(pkg_state), 1);
        chk("R7 sr low in C1", int'(dram_sr), 0);

        // R8 direct idle-to-idle moves
        set_all(3'd6); tick();
        chk("R8 enter C6", int'(pkg_state), 6);
        set_all(3'd3); tick();
        chk("R8 C6 to C3 direct", int'(pkg_state), 3);
        set_all(3'd1); tick();
        chk("R8 C3 to C1 direct", int'(pkg_state), 1);

        // R3 inactive cores excluded
        set_all(3'd0); core_req[2:0] = 3'd6; core_active = 4'b0001; tick();
        chk("R3 inactive C0 ignored", int'(pkg_state), 6);
        core_active = 4'b0000; tick();
        chk("R3 no active gives C6", int'(pkg_state), 6);
        plat_limit = 3'd3; tick();
        chk("R3 no active capped", int'(pkg_state), 3);
        core_active = '1;

        // R4 platform ceiling
        set_all(3'd6); tick();
        chk("R4 ceiling C3", int'(pkg_state), 3);
        plat_limit = 3'd2; tick();
        chk("R4 ceiling code 2 is C1", int'(pkg_state), 1);
        plat_limit = 3'd6;

        // R5 / R6 hold and enhanced C1
        plat_hold = 1'b1; tick();
        chk("R5 hold caps at C1", int'(pkg_state), 1);
        c1e_en = 1'b1; tick();
        chk("R6 hold with C1E", int'(pkg_state), 2);
        plat_hold = 1'b0; set_all(3'd1); tick();
        chk("R6 all C1 gives C1E", int'(pkg_state), 2);
        core_req[2:0] = 3'd0; tick();
        chk("R6 C0 core blocks C1E", int'(pkg_state), 0);
        c1e_en = 1'b0; set_all(3'd1); tick();
        chk("R6 disabled stays C1", int'(pkg_state), 1);

        // R9 unmasked core break
        set_all(3'd6); tick();
        core_brk = 4'b0100; tick(); clr_brk();
        chk("R9 unmasked to C0", int'(pkg_state), 0);
        chk("R9 wake core2", int'(core_wake), 4);
        chk("R7 sr released", int'(dram_sr), 0);
        tick();
        chk("R9 held at C0", int'(pkg_state), 0);
        chk("R9 wake one cycle", int'(core_wake), 0);
        core_req[8:6] = 3'd0; tick();
        chk("R9 released by C0 request", int'(pkg_state), 0);
        core_req[8:6] = 3'd6; tick();
        chk("R9 resolution resumes", int'(pkg_state), 6);

        // R10 masked core break restores previous
        set_all(3'd3); tick();
        core_brk = 4'b0010; core_brk_mask = 4'b0010; tick(); clr_brk();
        chk("R10 masked to C0", int'(pkg_state), 0);
        chk("R10 wake core1", int'(core_wake), 2);
        set_all(3'd6); tick();
        chk("R10 restored C3", int'(pkg_state), 3);
        tick();
        chk("R10 then resolves C6", int'(pkg_state), 6);

        // R11 memory break without hold
        set_all(3'd3); tick();
        mem_brk = 1'b1; tick(); clr_brk();
        chk("R11 strobe", int'(svc_strobe), 1);
        chk("R11 C0 while serviced", int'(pkg_state), 0);
        set_all(3'd6); tick();
        chk("R11 restored C3", int'(pkg_state), 3);
        chk("R11 strobe one cycle", int'(svc_strobe), 0);
        tick();
        chk("R11 then resolves C6", int'(pkg_state), 6);

        // R12 memory break with hold
        set_all(3'd3); tick();
        mem_brk = 1'b1; plat_hold = 1'b1; tick(); clr_brk();
        chk("R12 strobe", int'(svc_strobe), 1);
        tick();
        chk("R12 stays shallow", int'(pkg_state), 1);
        plat_hold = 1'b0; tick();
        chk("R12 back to C3", int'(pkg_state), 3);

        // R13 priority
        set_all(3'd6); tick();
        core_brk = 4'b0110; mem_brk = 1'b1; tick(); clr_brk();
        chk("R13 lowest core wins", int'(core_wake), 2);
        chk("R13 memory event dropped", int'(svc_strobe), 0);
        core_active = 4'b1101; tick();
        chk("R13 target is core1", int'(pkg_state), 6);
        core_active = '1;

        // R14 saved state survives a break in restore
        set_all(3'd3); tick();
        core_brk = 4'b0001; core_brk_mask = 4'b0001; tick(); clr_brk();
        mem_brk = 1'b1; set_all(3'd6); tick(); clr_brk();
        chk("R14 second break serviced", int'(svc_strobe), 1);
        tick();
        chk("R14 original state restored", int'(pkg_state), 3);
        tick();
        chk("R14 then resolves C6", int'(pkg_state), 6);

        // Constrained random phase against the model
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < N; i++) begin
                core_req[i*3 +: 3] = rnd_code();
                core_active[i]     = ($urandom % 8) != 0;
                core_brk[i]        = ($urandom % 24) == 0;
                core_brk_mask[i]   = $urandom % 2;
            end
            mem_brk   = ($urandom % 12) == 0;
            plat_hold = ($urandom % 10) == 0;
            if (($urandom % 16) == 0) plat_limit = 3'($urandom % 8);
            if (($urandom % 32) == 0) c1e_en = ~c1e_en;
            tick();
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule